// File: doc/BRIEF.md
# Flash Sector Lock Register Unit

This unit keeps the program/erase lock bits of an embedded flash controller for two address spaces: a low space of up to 16 sectors and a high space of up to 6 sectors. After every reset all lock bits read as locked. They stay locked until the controller's loader presents a 64-bit word read from the non-volatile test sector and pulses `nv_valid`. From then on, software may rewrite the bits through a small register port. Such writes are refused while a program/erase operation is in flight or suspended. Writes to the low space also need the lock-enable flag.

A parameter mask lists which sectors physically exist. Bits for absent sectors are locked permanently. They ignore both the image and register writes, and they always read back as 1. When a program or erase request arrives, the unit combines each lock bit with an external secondary lock bit. It captures a per-sector permit vector, and that vector holds until the next request.

Top module: `flash_lock_unit`

## Requirements
- R1: After reset and before the first `nv_valid` pulse, every lock bit is 1. Low readback (`reg_sel`=0) is 0x0000FFFF, high readback (`reg_sel`=1) is 0x0000003F, and both permit outputs are 0.
- R2: The first `nv_valid` after reset loads the low bits from `nv_image[15:0]` and the high bits from `nv_image[21:16]`. Absent sectors are forced to 1. Bits 63:22 of the image have no effect.
- R3: An `nv_valid` pulse after the load is ignored. A new reset followed by `nv_valid` applies a changed image.
- R4: A write with `reg_sel`=0 changes the low bits only when `lock_en` is 1. Writes with `reg_sel`=1 do not depend on `lock_en`.
- R5: After an `hv_start` pulse, writes to either space are ignored. This lasts until the clock edge on which `hv_done` is sampled high. Writes in later cycles take effect.
- R6: While `hv_suspended` is 1, writes to either space are ignored.
- R7: Absent sector bits (the low space presents bits 3:0 by default) always read 1 and ignore writes. High readback bits 31:6 and low readback bits 31:16 read 0.
- R8: On a clock edge with `pe_req`=1, `permit_lo`/`permit_hi` capture NOT(lock OR secondary lock) AND present mask. They become visible one cycle later and hold their value until the next request.
- R9: Register writes before the first `nv_valid` after reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_valid | input | 1 | Strobe: non-volatile image is valid |
| nv_image | input | 64 | Non-volatile lock image |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = low space, 1 = high space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Readback of the selected space |
| lock_en | input | 1 | Enables low-space writes |
| hv_start | input | 1 | Interlock write started an operation |
| hv_done | input | 1 | Operation completed |
| hv_suspended | input | 1 | Operation suspended |
| sec_lock_lo | input | 16 | Secondary lock, low space |
| sec_lock_hi | input | 6 | Secondary lock, high space |
| pe_req | input | 1 | Program/erase request |
| permit_lo | output | 16 | Latched per-sector permit, low space |
| permit_hi | output | 6 | Latched per-sector permit, high space |

## Verification
Readback is combinational from the lock flops, so any wrong lock bit appears on `reg_rdata` in the cycle after the edge that corrupted it. A wrongly opened write gate shows as a changed readback right after the refused write. A stale interlock flag shows as a rejected write after `hv_done`. A bad permit shows one cycle after `pe_req`, and it stays wrong until the next request. That includes permits for sectors that do not exist.

// File: rtl/flk_pkg.sv
// Package: shared sizes and select encoding for the flash lock unit.
// Assumes a 32-bit register port and a 64-bit non-volatile image.
package flk_pkg;
    localparam int REG_W    = 32;
    localparam int NV_W     = 64;
    localparam int LO_W_DEF = 16;
    localparam int HI_W_DEF = 6;

    typedef enum logic {
        SPACE_LO = 1'b0,
        SPACE_HI = 1'b1
    } flk_space_e;
endpackage

// File: rtl/flk_write_gate.sv
// Module: tracks load and interlock state, produces per-space write and load strobes.
// Assumes hv_start/hv_done are single-cycle pulses from the sequencer.
module flk_write_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic nv_valid,
    input  logic hv_start,
    input  logic hv_done,
    input  logic hv_suspended,
    input  logic lock_en,
    input  logic reg_wr,
    input  logic reg_sel,
    output logic load_pulse,
    output logic wr_lo,
    output logic wr_hi
);
    import flk_pkg::*;

    logic loaded_q;
    logic busy_q;
    logic wr_ok;

    // Purpose: remember that the image has been taken since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          loaded_q <= 1'b0;
        else if (load_pulse) loaded_q <= 1'b1;
    end

    // Purpose: interlock flag, set by an operation start, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= hv_start | (busy_q & ~hv_done);
    end

    // Purpose: decode the gating conditions into strobes.
    always_comb begin
        load_pulse = nv_valid & ~loaded_q;
        wr_ok      = reg_wr & loaded_q & ~busy_q & ~hv_suspended;
        wr_lo      = wr_ok & (reg_sel == SPACE_LO) & lock_en;
        wr_hi      = wr_ok & (reg_sel == SPACE_HI);
    end
endmodule

// File: rtl/flk_lock_bank.sv
// Module: one space's lock bits; absent sectors are forced to 1 on every update.
// Assumes load and write strobes come from flk_write_gate (load has priority).
module flk_lock_bank #(
    parameter int          W       = 16,
    parameter logic [W-1:0] PRESENT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] lock_q
);
    localparam logic [W-1:0] ABSENT = ~PRESENT;

    // Purpose: hold lock bits; reset locks all, load/write keep absent bits set.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= '1;
        else if (load_en) lock_q <= load_val | ABSENT;
        else if (wr_en)   lock_q <= wr_val | ABSENT;
    end
endmodule

// File: rtl/flk_permit_latch.sv
// Module: captures per-sector permission when a program/erase request arrives.
// Assumes secondary lock bits are stable in the request cycle.
module flk_permit_latch #(
    parameter int          W       = 16,
    parameter logic [W-1:0] PRESENT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pe_req,
    input  logic [W-1:0] lock_q,
    input  logic [W-1:0] sec_q,
    output logic [W-1:0] permit
);
    // Purpose: sample combined permission on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      permit <= '0;
        else if (pe_req) permit <= ~(lock_q | sec_q) & PRESENT;
    end
endmodule

// File: rtl/flash_lock_unit.sv
// Module: top of the flash sector lock unit; two lock banks, gating and permit capture.
// Assumes LO_W and HI_W are below the register width and the image holds low then high.
module flash_lock_unit #(
    parameter int              LO_W       = flk_pkg::LO_W_DEF,
    parameter int              HI_W       = flk_pkg::HI_W_DEF,
    parameter logic [LO_W-1:0] LO_PRESENT = 16'h000F,
    parameter logic [HI_W-1:0] HI_PRESENT = 6'h3F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     nv_valid,
    input  logic [flk_pkg::NV_W-1:0]  nv_image,
    input  logic                     reg_wr,
    input  logic                     reg_sel,
    input  logic [flk_pkg::REG_W-1:0] reg_wdata,
    output logic [flk_pkg::REG_W-1:0] reg_rdata,
    input  logic                     lock_en,
    input  logic                     hv_start,
    input  logic                     hv_done,
    input  logic                     hv_suspended,
    input  logic [LO_W-1:0]          sec_lock_lo,
    input  logic [HI_W-1:0]          sec_lock_hi,
    input  logic                     pe_req,
    output logic [LO_W-1:0]          permit_lo,
    output logic [HI_W-1:0]          permit_hi
);
    import flk_pkg::*;

    localparam int HI_LSB = LO_W;
    localparam int HI_MSB = LO_W + HI_W - 1;

    logic            load_pulse;
    logic            wr_lo;
    logic            wr_hi;
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            unused_inputs;

    // Purpose: image bits above the high field and unused write bits are ignored.
    assign unused_inputs = ^{nv_image[NV_W-1:HI_MSB+1], reg_wdata[REG_W-1:LO_W]};

    flk_write_gate gate_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .nv_valid     (nv_valid),
        .hv_start     (hv_start),
        .hv_done      (hv_done),
        .hv_suspended (hv_suspended),
        .lock_en      (lock_en),
        .reg_wr       (reg_wr),
        .reg_sel      (reg_sel),
        .load_pulse   (load_pulse),
        .wr_lo        (wr_lo),
        .wr_hi        (wr_hi)
    );

    flk_lock_bank #(.W(LO_W), .PRESENT(LO_PRESENT)) lo_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_pulse),
        .load_val (nv_image[LO_W-1:0]),
        .wr_en    (wr_lo),
        .wr_val   (reg_wdata[LO_W-1:0]),
        .lock_q   (lo_q)
    );

    flk_lock_bank #(.W(HI_W), .PRESENT(HI_PRESENT)) hi_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_pulse),
        .load_val (nv_image[HI_MSB:HI_LSB]),
        .wr_en    (wr_hi),
        .wr_val   (reg_wdata[HI_W-1:0]),
        .lock_q   (hi_q)
    );

    flk_permit_latch #(.W(LO_W), .PRESENT(LO_PRESENT)) lo_permit_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pe_req (pe_req),
        .lock_q (lo_q),
        .sec_q  (sec_lock_lo),
        .permit (permit_lo)
    );

    flk_permit_latch #(.W(HI_W), .PRESENT(HI_PRESENT)) hi_permit_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pe_req (pe_req),
        .lock_q (hi_q),
        .sec_q  (sec_lock_hi),
        .permit (permit_hi)
    );

    // Purpose: readback of the selected space, zero above its width.
    always_comb begin
        if (reg_sel == SPACE_HI) reg_rdata = {{(REG_W-HI_W){1'b0}}, hi_q};
        else                     reg_rdata = {{(REG_W-LO_W){1'b0}}, lo_q};
    end
endmodule

// File: rtl/flk_checker.sv
// Module: assertion checker for flash_lock_unit, attached by bind.
// Assumes it observes the top ports and both lock banks' outputs.
module flk_checker #(
    parameter int              LO_W       = 16,
    parameter int              HI_W       = 6,
    parameter logic [LO_W-1:0] LO_PRESENT = '1,
    parameter logic [HI_W-1:0] HI_PRESENT = '1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic            reg_sel,
    input logic            lock_en,
    input logic            hv_suspended,
    input logic            nv_valid,
    input logic            pe_req,
    input logic [31:0]     reg_rdata,
    input logic [LO_W-1:0] permit_lo,
    input logic [HI_W-1:0] permit_hi,
    input logic [LO_W-1:0] lo_q,
    input logic [HI_W-1:0] hi_q
);
    a_r7_low_absent_set: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (((reg_rdata[LO_W-1:0] & ~LO_PRESENT) == ~LO_PRESENT)
                      && (reg_rdata[31:LO_W] == '0)));

    a_r7_high_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[31:HI_W] == '0));

    a_r8_permit_present_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((permit_lo & ~LO_PRESENT) == '0) && ((permit_hi & ~HI_PRESENT) == '0));

    a_r8_permit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_req |=> ($stable(permit_lo) && $stable(permit_hi)));

    a_r4_lock_en_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !lock_en && !nv_valid) |=> $stable(lo_q));

    a_r6_suspend_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hv_suspended && !nv_valid) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

bind flash_lock_unit flk_checker #(
    .LO_W(LO_W), .HI_W(HI_W), .LO_PRESENT(LO_PRESENT), .HI_PRESENT(HI_PRESENT)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .lock_en      (lock_en),
    .hv_suspended (hv_suspended),
    .nv_valid     (nv_valid),
    .pe_req       (pe_req),
    .reg_rdata    (reg_rdata),
    .permit_lo    (permit_lo),
    .permit_hi    (permit_hi),
    .lo_q         (lo_q),
    .hi_q         (hi_q)
);

// File: tb/flash_lock_unit_tb_top.sv
// Bench: vector table for register gating, then directed reset/interlock/permit tests.
module flash_lock_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nv_valid = 1'b0;
    logic [63:0] nv_image = '0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lock_en = 1'b0;
    logic        hv_start = 1'b0;
    logic        hv_done = 1'b0;
    logic        hv_suspended = 1'b0;
    logic [15:0] sec_lock_lo = '0;
    logic [5:0]  sec_lock_hi = '0;
    logic        pe_req = 1'b0;
    logic [15:0] permit_lo;
    logic [5:0]  permit_hi;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    flash_lock_unit dut_i (.*);

    // vector: {sel, wdata[31:0], lock_en, suspended, expected[31:0]}
    localparam int NV = 9;
    localparam logic [66:0] VEC [NV] = '{
        {1'b0, 32'h0000_0003, 1'b1, 1'b0, 32'h0000_FFF3},  // R4 enabled write
        {1'b0, 32'h0000_000A, 1'b0, 1'b0, 32'h0000_FFF3},  // R4 disabled
        {1'b0, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_FFF3},  // R6 suspended
        {1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_FFF0},  // R7 absent stay 1
        {1'b1, 32'hFFFF_FFC5, 1'b0, 1'b0, 32'h0000_0005},  // R4/R7 high ignores lock_en
        {1'b1, 32'h0000_003F, 1'b1, 1'b1, 32'h0000_0005},  // R6 high suspended
        {1'b1, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000},  // R7 high clear
        {1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0000_FFFF},  // R7 upper readback zero
        {1'b0, 32'h0000_0009, 1'b1, 1'b0, 32'h0000_FFF9}   // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d, input logic en, input logic sus);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; lock_en = en; hv_suspended = sus; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; hv_suspended = 1'b0; lock_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic sel, input logic [31:0] exp);
        reg_sel = sel;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse_nv(input logic [63:0] img);
        @(negedge clk);
        nv_image = img; nv_valid = 1'b1;
        @(negedge clk);
        nv_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        read_chk("R1 low", 1'b0, 32'h0000_FFFF);
        read_chk("R1 high", 1'b1, 32'h0000_003F);
        check("R1 permit_lo", {16'h0, permit_lo}, 32'h0);
        check("R1 permit_hi", {26'h0, permit_hi}, 32'h0);

        // R9 write before load ignored
        reg_write(1'b0, 32'h0, 1'b1, 1'b0);
        read_chk("R9 low", 1'b0, 32'h0000_FFFF);

        // R2 load: low image 0x0005, high field 0x2A, upper bits junk
        pulse_nv(64'h1234_5678_FFEA_0005);
        read_chk("R2 low", 1'b0, 32'h0000_FFF5);
        read_chk("R2 high", 1'b1, 32'h0000_002A);

        // R3 second strobe ignored
        pulse_nv(64'h0);
        read_chk("R3 low", 1'b0, 32'h0000_FFF5);
        read_chk("R3 high", 1'b1, 32'h0000_002A);

        for (int i = 0; i < NV; i++) begin
            reg_write(VEC[i][66], VEC[i][65:34], VEC[i][33], VEC[i][32]);
            read_chk($sformatf("vec%0d R4/R6/R7", i), VEC[i][66], VEC[i][31:0]);
        end

        // R5 interlock: low=0xFFF9, high=0x00
        @(negedge clk); hv_start = 1'b1;
        @(negedge clk); hv_start = 1'b0;
        reg_write(1'b0, 32'h0, 1'b1, 1'b0);
        read_chk("R5 low blocked", 1'b0, 32'h0000_FFF9);
        reg_write(1'b1, 32'h3F, 1'b1, 1'b0);
        read_chk("R5 high blocked", 1'b1, 32'h0000_0000);
        @(negedge clk); hv_done = 1'b1;
        @(negedge clk); hv_done = 1'b0;
        reg_write(1'b0, 32'h6, 1'b1, 1'b0);
        read_chk("R5 low after done", 1'b0, 32'h0000_FFF6);

        // R8 permit capture
        @(negedge clk);
        sec_lock_lo = 16'h0002; sec_lock_hi = 6'h05; pe_req = 1'b1;
        @(negedge clk);
        pe_req = 1'b0;
        check("R8 permit_lo", {16'h0, permit_lo}, 32'h0000_0009);
        check("R8 permit_hi", {26'h0, permit_hi}, 32'h0000_003A);
        sec_lock_lo = 16'h0000; sec_lock_hi = 6'h3F;
        repeat (2) @(negedge clk);
        check("R8 permit_lo hold", {16'h0, permit_lo}, 32'h0000_0009);
        check("R8 permit_hi hold", {26'h0, permit_hi}, 32'h0000_003A);

        // R3 reset reloads a changed image
        do_reset();
        read_chk("R1 low after reset", 1'b0, 32'h0000_FFFF);
        read_chk("R1 high after reset", 1'b1, 32'h0000_003F);
        check("R1 permit cleared", {16'h0, permit_lo}, 32'h0);
        pulse_nv(64'hFFFF_FFFF_0000_0000);
        read_chk("R3 reload low", 1'b0, 32'h0000_FFF0);
        read_chk("R3 reload high", 1'b1, 32'h0000_0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule